// File: doc/BRIEF.md
# Bit-Serial Interleaved Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder for a telemetry path. It takes information bytes one at a time and updates the check symbols as each byte arrives, so the codeblock is never buffered. The multiplication by the generator coefficients is done one bit per clock. Each coefficient has its own small shift register, and a fixed XOR network replaces any parallel GF(256) multiplier. The output is already a serial bit stream: the information bits come out while they are being encoded, and the check bits follow after the last information byte. No separate serializer is needed.

Up to five codewords can be interleaved. The interleave depth is taken from an input port when the first byte of a block is accepted. Consecutive input bytes then go to the codewords in rotation, and the check symbols leave in the same rotation. The parity banks empty themselves while the check bits are shifted out, so the next block can start right away.

Control is a three-state machine. S_IDLE waits for a byte and moves to S_DATA when one is accepted. S_DATA lasts eight cycles per byte. At the last bit of a byte it goes to S_CHECK if that byte ends the information part, stays in S_DATA if a new byte is accepted in that cycle, and otherwise falls back to S_IDLE. S_CHECK shifts out all check bits and returns to S_IDLE after the final bit.

Top module: `rs_il_encoder`

## Requirements
- R1: Each codeword is RS(255,223) over GF(256) with field polynomial x^8+x^7+x^2+x+1 (low byte 0x87). The generator has roots alpha^0 to alpha^31, where alpha is the element x. The 32 check symbols are the remainder of the information polynomial times x^32, divided by the generator. They are sent highest-degree symbol first, and every symbol goes out MSB first.
- R2: Each accepted byte appears on `ser_bit` in the eight cycles that follow its acceptance, MSB first, with `ser_valid` high and `ser_check` low.
- R3: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high in S_IDLE and in the last bit cycle of S_DATA, except when that byte is the final information byte of the block.
- R4: With interleave depth I, byte k of a block goes to codeword k mod I. I is read from `depth` when the block's first byte is accepted: 0 selects 1, and any value above 5 selects 5.
- R5: After 223*I information bytes, 32*I check bytes follow with `ser_check` high. For each symbol position, from highest degree to lowest, codewords 0 to I-1 are sent in turn. `in_ready` stays low for the whole check phase.
- R6: `ser_last` is high only with the final check bit of a block.
- R7: All parity state is zero after each block. The next block's check symbols depend only on its own bytes.
- R8: When input bytes are offered without pause, `ser_valid` has no idle cycle between the first and last bit of a block (eight cycles per byte).
- R9: `in_valid` and `in_byte` during the check phase have no effect on the output.
- R10: After reset, `ser_valid`, `ser_check` and `ser_last` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Information byte offered |
| in_byte | input | 8 | Information byte |
| in_ready | output | 1 | Encoder takes a byte this cycle |
| depth | input | 3 | Interleave depth, sampled at block start |
| ser_valid | output | 1 | `ser_bit` carries an output bit |
| ser_bit | output | 1 | Serial output bit |
| ser_check | output | 1 | Current bit is a check bit |
| ser_last | output | 1 | Final bit of the block |

## Verification
The checker watches the handshake and framing signals on every cycle:
- `in_ready` never rises during the check phase.
- `ser_check` and `ser_last` appear only with `ser_valid`.
- An accepted byte is followed by a data bit.
- The check phase ends after `ser_last`.

The arithmetic can only be shown by the bench scenarios, which compare every output bit against a table-based reference encoder. These scenarios cover:
- the correctness of the parity;
- the interleave rotation and the clamping of out-of-range depths;
- the self-clearing between blocks;
- gap-free output under continuous input;
- the input being ignored during the check phase.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
    localparam int SYM_W      = 8;
    localparam int NPAR       = 32;
    localparam int NINFO      = 223;
    localparam int IL_MAX_DEF = 5;
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h87;

    typedef enum logic [1:0] {S_IDLE, S_DATA, S_CHECK} enc_state_t;

    function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_LOW : '0);
    endfunction

    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] r;
        r = '0;
        for (int i = SYM_W-1; i >= 0; i--) begin
            r = gf_xtime(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // Low NPAR coefficients of the monic generator with roots alpha^0..alpha^(NPAR-1)
    function automatic logic [NPAR*SYM_W-1:0] gen_coefs();
        logic [SYM_W-1:0] g [NPAR+1];
        logic [SYM_W-1:0] root;
        logic [NPAR*SYM_W-1:0] res;
        for (int i = 0; i <= NPAR; i++) g[i] = '0;
        g[0] = 8'h01;
        root = 8'h01;
        for (int j = 0; j < NPAR; j++) begin
            for (int i = NPAR; i >= 1; i--) g[i] = g[i-1] ^ gf_mul(g[i], root);
            g[0] = gf_mul(g[0], root);
            root = gf_xtime(root);
        end
        for (int i = 0; i < NPAR; i++) res[i*SYM_W +: SYM_W] = g[i];
        return res;
    endfunction
endpackage

// File: rtl/rs_serial_mul.sv
module rs_serial_mul
    import rs_enc_pkg::*;
#(
    parameter logic [SYM_W-1:0] COEF = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             first,
    input  logic             fbit,
    output logic [SYM_W-1:0] prod_next
);
    logic [SYM_W-1:0] acc_q;
    logic [SYM_W-1:0] base;

    // Horner step, feedback bits MSB first: acc = acc*alpha + bit*COEF
    always_comb begin
        base      = first ? '0 : acc_q;
        prod_next = gf_xtime(base) ^ (fbit ? COEF : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (step) acc_q <= prod_next;
    end
endmodule

// File: rtl/rs_check_store.sv
module rs_check_store
    import rs_enc_pkg::*;
#(
    parameter int BANKS = 5,
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  upd,
    input  logic                  shift,
    input  logic [NPAR*SYM_W-1:0] prod,
    output logic [SYM_W-1:0]      top_sym
);
    logic [BANKS-1:0][SYM_W-1:0] tops;

    for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
        logic [SYM_W-1:0] regs [NPAR];
        logic             hit;
        assign hit = (sel == SEL_W'(gb));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NPAR; i++) regs[i] <= '0;
            end else if (hit && upd) begin
                regs[0] <= prod[0 +: SYM_W];
                for (int i = 1; i < NPAR; i++)
                    regs[i] <= regs[i-1] ^ prod[i*SYM_W +: SYM_W];
            end else if (hit && shift) begin
                regs[0] <= '0;
                for (int i = 1; i < NPAR; i++) regs[i] <= regs[i-1];
            end
        end

        assign tops[gb] = regs[NPAR-1];
    end

    assign top_sym = tops[sel];
endmodule

// File: rtl/rs_il_encoder.sv
module rs_il_encoder
    import rs_enc_pkg::*;
#(
    parameter int INTERLEAVE_MAX = IL_MAX_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic [2:0] depth,
    output logic       ser_valid,
    output logic       ser_bit,
    output logic       ser_check,
    output logic       ser_last
);
    localparam int SEL_W = (INTERLEAVE_MAX > 1) ? $clog2(INTERLEAVE_MAX) : 1;
    localparam int RND_W = $clog2(NINFO);
    localparam int BIT_W = $clog2(SYM_W);
    localparam logic [NPAR*SYM_W-1:0] GEN = gen_coefs();

    enc_state_t       st_q, st_d;
    logic [BIT_W-1:0] bitc_q;
    logic [SYM_W-1:0] data_q;
    logic [SEL_W-1:0] cw_q, dep_q;
    logic [RND_W-1:0] rnd_q;
    logic [SYM_W-1:0] top_sym;
    logic [NPAR*SYM_W-1:0] prod;
    logic accept, bit_last, cw_wrap, info_done, chk_done, block_start;
    logic fbit, step, first, upd, shift;
    logic [BIT_W-1:0] bsel;

    function automatic logic [SEL_W-1:0] depth_to_last(input logic [2:0] d);
        if (d == 3'd0)                    return '0;
        else if (int'(d) > INTERLEAVE_MAX) return SEL_W'(INTERLEAVE_MAX - 1);
        else                               return SEL_W'(int'(d) - 1);
    endfunction

    assign bsel        = BIT_W'(SYM_W - 1) - bitc_q;
    assign bit_last    = (bitc_q == BIT_W'(SYM_W - 1));
    assign cw_wrap     = (cw_q == dep_q);
    assign info_done   = cw_wrap && (rnd_q == RND_W'(NINFO - 1));
    assign chk_done    = cw_wrap && (rnd_q == RND_W'(NPAR - 1));
    assign block_start = (st_q == S_IDLE) && (cw_q == '0) && (rnd_q == '0);
    assign accept      = in_valid && in_ready;

    // Datapath controls
    assign step  = (st_q == S_DATA);
    assign first = (bitc_q == '0);
    assign fbit  = data_q[bsel] ^ top_sym[bsel];
    assign upd   = (st_q == S_DATA) && bit_last;
    assign shift = (st_q == S_CHECK) && bit_last;

    for (genvar gi = 0; gi < NPAR; gi++) begin : g_mul
        rs_serial_mul #(.COEF(GEN[gi*SYM_W +: SYM_W])) u_mul (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (step),
            .first     (first),
            .fbit      (fbit),
            .prod_next (prod[gi*SYM_W +: SYM_W])
        );
    end

    rs_check_store #(.BANKS(INTERLEAVE_MAX), .SEL_W(SEL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cw_q),
        .upd     (upd),
        .shift   (shift),
        .prod    (prod),
        .top_sym (top_sym)
    );

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (accept) st_d = S_DATA;
            S_DATA:  if (bit_last) begin
                         if (info_done)   st_d = S_CHECK;
                         else if (accept) st_d = S_DATA;
                         else             st_d = S_IDLE;
                     end
            S_CHECK: if (bit_last && chk_done) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Counters and byte latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitc_q <= '0;
            data_q <= '0;
            cw_q   <= '0;
            rnd_q  <= '0;
            dep_q  <= '0;
        end else begin
            if (accept) data_q <= in_byte;
            if (accept && block_start) dep_q <= depth_to_last(depth);
            if (st_q != S_IDLE) bitc_q <= bitc_q + 1'b1;
            if (st_q != S_IDLE && bit_last) begin
                if (cw_wrap) begin
                    cw_q <= '0;
                    if ((st_q == S_DATA && info_done) || (st_q == S_CHECK && chk_done))
                        rnd_q <= '0;
                    else
                        rnd_q <= rnd_q + 1'b1;
                end else begin
                    cw_q <= cw_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        ser_valid = 1'b0;
        ser_bit   = 1'b0;
        ser_check = 1'b0;
        ser_last  = 1'b0;
        unique case (st_q)
            S_IDLE:  in_ready = 1'b1;
            S_DATA:  begin
                         in_ready  = bit_last && !info_done;
                         ser_valid = 1'b1;
                         ser_bit   = data_q[bsel];
                     end
            S_CHECK: begin
                         ser_valid = 1'b1;
                         ser_check = 1'b1;
                         ser_bit   = top_sym[bsel];
                         ser_last  = bit_last && chk_done;
                     end
            default: ;
        endcase
    end
endmodule

// File: rtl/rs_il_encoder_checker.sv
module rs_il_encoder_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic ser_valid,
    input logic ser_check,
    input logic ser_last
);
    a_r5_no_ready_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        ser_check |-> !in_ready);

    a_r5_check_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ser_check |-> ser_valid);

    a_r6_last_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> (ser_check && ser_valid));

    a_r6_check_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |=> !ser_check);

    a_r2_accept_gives_data: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (ser_valid && !ser_check));
endmodule

bind rs_il_encoder rs_il_encoder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ser_valid (ser_valid),
    .ser_check (ser_check),
    .ser_last  (ser_last)
);

// File: tb/rs_il_encoder_bench.sv
module rs_il_encoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic [2:0] depth = 3'd1;
    logic       ser_valid, ser_bit, ser_check, ser_last;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rs_il_encoder u_rs_il_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .depth(depth), .ser_valid(ser_valid),
        .ser_bit(ser_bit), .ser_check(ser_check), .ser_last(ser_last)
    );

    int gexp [512];
    int glog [256];
    int gpoly [33];
    bit exp_bit [$];
    bit exp_chk [$];
    bit exp_last [$];
    bit contig_q [$];
    bit in_blk = 1'b0;
    int gaps = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int gmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return gexp[glog[a] + glog[b]];
    endfunction

    function automatic void init_field();
        int x = 1;
        for (int i = 0; i < 255; i++) begin
            gexp[i] = x; gexp[i+255] = x; glog[x] = i;
            x = x << 1;
            if ((x & 256) != 0) x = x ^ 'h187;
        end
        for (int i = 0; i <= 32; i++) gpoly[i] = 0;
        gpoly[0] = 1;
        for (int j = 0; j < 32; j++) begin
            for (int i = 32; i >= 1; i--) gpoly[i] = gpoly[i-1] ^ gmul(gpoly[i], gexp[j]);
            gpoly[0] = gmul(gpoly[0], gexp[j]);
        end
    endfunction

    function automatic void push_byte(input int b, input bit is_chk, input bit lastb);
        for (int i = 7; i >= 0; i--) begin
            exp_bit.push_back(b[i]);
            exp_chk.push_back(is_chk);
            exp_last.push_back(lastb && i == 0);
        end
    endfunction

    // Reference block: R1 parity, R4 rotation, R5 order; fresh parity per block (R7)
    task automatic send_block(input int dport, input int kind, input bit with_gaps);
        int il;
        int par [5][32];
        int bytes [$];
        il = (dport == 0) ? 1 : ((dport > 5) ? 5 : dport);
        for (int c = 0; c < 5; c++) for (int i = 0; i < 32; i++) par[c][i] = 0;
        for (int k = 0; k < 223*il; k++) begin
            int b, c, fb;
            case (kind)
                0: b = k & 255;
                1: b = $urandom & 255;
                default: b = 255;
            endcase
            bytes.push_back(b);
            c = k % il;
            fb = b ^ par[c][31];
            for (int i = 31; i >= 1; i--) par[c][i] = par[c][i-1] ^ gmul(gpoly[i], fb);
            par[c][0] = gmul(gpoly[0], fb);
            push_byte(b, 1'b0, 1'b0);
        end
        for (int s = 31; s >= 0; s--)
            for (int c = 0; c < il; c++)
                push_byte(par[c][s], 1'b1, (s == 0) && (c == il-1));
        contig_q.push_back(!with_gaps);
        depth = 3'(dport);
        for (int k = 0; k < bytes.size(); k++) begin
            if (with_gaps) begin
                in_valid = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = 8'(bytes[k]);
            @(negedge clk);
        end
        // R9: junk offered throughout the check phase
        in_valid = 1'b1;
        in_byte  = 8'hA5;
    endtask

    // Per-cycle comparison against the reference stream
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ser_valid) begin
                if (!in_blk) begin in_blk = 1'b1; gaps = 0; end
                if (exp_bit.size() == 0) begin
                    chk(1'b0, "R3 unexpected output bit", 1, 0);
                end else begin
                    bit eb, ec, el;
                    eb = exp_bit.pop_front();
                    ec = exp_chk.pop_front();
                    el = exp_last.pop_front();
                    chk(ser_bit == eb, ec ? "R1 check bit" : "R2 data bit", int'(ser_bit), int'(eb));
                    chk(ser_check == ec, "R5 check flag", int'(ser_check), int'(ec));
                    chk(ser_last == el, "R6 last flag", int'(ser_last), int'(el));
                    chk(!(ec && in_ready), "R5 ready in check", int'(in_ready), 0);
                end
                if (ser_last) begin
                    in_blk = 1'b0;
                    if (contig_q.size() != 0 && contig_q.pop_front())
                        chk(gaps == 0, "R8 idle cycles in block", gaps, 0);
                end
            end else if (in_blk) begin
                gaps++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        init_field();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(ser_valid == 1'b0, "R10 ser_valid", int'(ser_valid), 0);
        chk(ser_check == 1'b0, "R10 ser_check", int'(ser_check), 0);
        chk(ser_last  == 1'b0, "R10 ser_last",  int'(ser_last), 0);
        chk(in_ready  == 1'b1, "R10 in_ready",  int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        send_block(1, 0, 1'b0);   // R1 R2 R8 depth one, counting bytes
        send_block(2, 1, 1'b0);   // R4 depth two, random
        send_block(0, 2, 1'b1);   // R4 clamp 0 -> 1, all ones, gaps (R3); R7 after prior blocks
        send_block(5, 1, 1'b0);   // R4 R5 full depth
        send_block(7, 1, 1'b1);   // R4 clamp 7 -> 5, gaps
        while (!ser_check) @(negedge clk);
        while (ser_check) @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_bit.size() == 0, "R5 missing output bits", exp_bit.size(), 0);
        chk(ser_valid == 1'b0, "R9 idle after block", int'(ser_valid), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule